// File: doc/BRIEF.md
# Temperature-Compensated Wiper Setting Unit

This unit holds the 7-bit wiper register of a digital resistor and decides what goes into it. It has three inputs that can supply a value. The first is a non-volatile initial value. The second is the entry fetched from a temperature-indexed table. The third is a value written by the host interface. Two mode bits choose how these are used:
- **Fixed mode:** the initial value alone drives the wiper.
- **Direct-table mode:** the table entry is loaded as is.
- **Adder mode:** the table entry is a signed 7-bit offset. It is added to the initial value and the sum is saturated to the wiper range.

Two more control bits allow manual operation:
- **Manual wiper:** host writes set the wiper directly, passed through the same direct or adder rule. Automatic frame loads are suppressed while this bit is set.
- **Manual index:** the host selects the table address itself. A strobe then applies the entry read from that address.

The surrounding logic performs the temperature conversion, stores the table and non-volatile bytes, and decodes the resistor. It raises `frame_done` once per conversion frame, after the new table entry is present on `tbl_val`. Host writes arrive as single-cycle strobes with their data.

Top module: `wiper_setting_unit`

## Requirements
- R1: While `rst` is high, the wiper is loaded with `init_val` at each clock. This power-up value stays in place until a load event occurs.
- R2: With `update_en`=0 (fixed mode), the wiper takes the current `init_val` one clock later on every clock. `frame_done`, `wiper_wr` and `index_wr` have no effect in this mode.
- R3: With `update_en`=1 and `adder_en`=0 (direct mode), a `frame_done` pulse loads `tbl_val` unchanged into the wiper one clock later.
- R4: With `update_en`=1 and `adder_en`=1 (adder mode), a `frame_done` pulse loads init_val + offset into the wiper one clock later, clamped to 0 and 127. The offset is `tbl_val` read as two's complement, with bit 6 as the sign, giving a range of -64..63. The sum is formed wide enough that no wrap can occur.
- R5: With `wiper_manual`=1, a `wiper_wr` pulse loads the wiper one clock later. In direct mode it loads `wiper_wdata`. In adder mode it loads the clamped sum of `init_val` and `wiper_wdata` read as a signed offset.
- R6: With `wiper_manual`=1, `frame_done` and `index_wr` leave the wiper unchanged.
- R7: With `wiper_manual`=0, `wiper_wr` leaves the wiper unchanged.
- R8: With `index_manual`=1 and `wiper_manual`=0, an `index_wr` pulse applies `tbl_val` through the current direct or adder rule one clock later. With `index_manual`=0, `index_wr` has no effect.
- R9: In the update modes, the wiper holds its value in any clock with no effective load strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the initial value |
| update_en | input | 1 | 1 = table-driven modes, 0 = fixed mode |
| adder_en | input | 1 | 1 = adder mode, 0 = direct mode (update modes only) |
| wiper_manual | input | 1 | 1 = host writes drive the wiper, frame loads suppressed |
| index_manual | input | 1 | 1 = host selects the table index; `index_wr` applies the entry |
| init_val | input | 7 | Non-volatile initial wiper value |
| tbl_val | input | 7 | Entry fetched from the table (signed offset in adder mode) |
| frame_done | input | 1 | One-cycle strobe at the end of a conversion frame |
| wiper_wr | input | 1 | One-cycle host write strobe for the wiper |
| wiper_wdata | input | 7 | Host write data for the wiper |
| index_wr | input | 1 | One-cycle strobe: a manually selected table entry is on `tbl_val` |
| wiper | output | 7 | Wiper register |

## Verification
Every result in this block is due exactly one clock after the stimulus that causes it, because the only register on any path is the wiper itself. The bench drives strobes and data on the falling edge. It lets one rising edge pass, then compares the wiper on the next falling edge, away from any edge where the register changes. When checking that a stimulus has no effect, the bench first loads a known value into the wiper. It then applies the stimulus and reads the wiper at that same one-clock point. The adder rule is swept over all 128 x 128 pairs of initial value and offset, so both clamp boundaries and every carry are covered.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    typedef enum logic [1:0] {
        MODE_FIXED  = 2'd0,
        MODE_DIRECT = 2'd1,
        MODE_ADDER  = 2'd2
    } wsc_mode_e;

    typedef enum logic [1:0] {
        SRC_INIT  = 2'd0,
        SRC_TABLE = 2'd1,
        SRC_WRITE = 2'd2
    } wsc_src_e;

    typedef struct packed {
        logic     load;
        wsc_src_e src;
    } wsc_load_t;

endpackage

// File: rtl/wsc_ctrl.sv
module wsc_ctrl
    import wsc_pkg::*;
(
    input  logic      update_en,
    input  logic      adder_en,
    input  logic      wiper_manual,
    input  logic      index_manual,
    input  logic      frame_done,
    input  logic      wiper_wr,
    input  logic      index_wr,
    output wsc_mode_e mode,
    output wsc_load_t req
);

    always_comb begin
        if (!update_en)
            mode = MODE_FIXED;
        else if (adder_en)
            mode = MODE_ADDER;
        else
            mode = MODE_DIRECT;
    end

    always_comb begin
        req.load = 1'b0;
        req.src  = SRC_TABLE;
        if (mode == MODE_FIXED) begin
            req.load = 1'b1;
            req.src  = SRC_INIT;
        end else if (wiper_manual) begin
            if (wiper_wr) begin
                req.load = 1'b1;
                req.src  = SRC_WRITE;
            end
        end else if (frame_done || (index_manual && index_wr)) begin
            req.load = 1'b1;
            req.src  = SRC_TABLE;
        end
    end

endmodule

// File: rtl/wsc_combine.sv
module wsc_combine #(
    parameter int W = 7
) (
    input  logic         add_en,
    input  logic [W-1:0] base,
    input  logic [W-1:0] entry,
    output logic [W-1:0] result
);

    localparam int SW = W + 2;
    localparam logic signed [SW-1:0] TOP = $signed({2'b00, {W{1'b1}}});

    logic signed [SW-1:0] sum;

    always_comb begin
        sum = $signed({2'b00, base}) + $signed({{2{entry[W-1]}}, entry});
        if (!add_en)
            result = entry;
        else if (sum < 0)
            result = '0;
        else if (sum > TOP)
            result = {W{1'b1}};
        else
            result = sum[W-1:0];
    end

    // a negative offset never raises, a positive one never lowers (R4)
    always_comb begin
        if (add_en && entry[W-1])
            assert_neg_offset_R4: assert (result <= base);
        if (add_en && !entry[W-1])
            assert_pos_offset_R4: assert (result >= base);
    end

endmodule

// File: rtl/wiper_setting_unit.sv
module wiper_setting_unit
    import wsc_pkg::*;
#(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         update_en,
    input  logic         adder_en,
    input  logic         wiper_manual,
    input  logic         index_manual,
    input  logic [W-1:0] init_val,
    input  logic [W-1:0] tbl_val,
    input  logic         frame_done,
    input  logic         wiper_wr,
    input  logic [W-1:0] wiper_wdata,
    input  logic         index_wr,
    output logic [W-1:0] wiper
);

    wsc_mode_e    mode;
    wsc_load_t    req;
    logic [W-1:0] tbl_res;
    logic [W-1:0] wr_res;
    logic         add_sel;

    wsc_ctrl u_ctrl (
        .update_en    (update_en),
        .adder_en     (adder_en),
        .wiper_manual (wiper_manual),
        .index_manual (index_manual),
        .frame_done   (frame_done),
        .wiper_wr     (wiper_wr),
        .index_wr     (index_wr),
        .mode         (mode),
        .req          (req)
    );

    assign add_sel = (mode == MODE_ADDER);

    wsc_combine #(.W(W)) u_tbl (
        .add_en (add_sel),
        .base   (init_val),
        .entry  (tbl_val),
        .result (tbl_res)
    );

    wsc_combine #(.W(W)) u_wr (
        .add_en (add_sel),
        .base   (init_val),
        .entry  (wiper_wdata),
        .result (wr_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wiper <= init_val;
        end else if (req.load) begin
            case (req.src)
                SRC_INIT:  wiper <= init_val;
                SRC_TABLE: wiper <= tbl_res;
                SRC_WRITE: wiper <= wr_res;
                default:   wiper <= wiper;
            endcase
        end
    end

    assert_reset_load_R1: assert property (@(posedge clk)
        rst |=> wiper == $past(init_val));

    assert_fixed_follows_R2: assert property (@(posedge clk) disable iff (rst)
        !update_en |=> wiper == $past(init_val));

    assert_direct_frame_R3: assert property (@(posedge clk) disable iff (rst)
        (update_en && !adder_en && !wiper_manual && frame_done) |=> wiper == $past(tbl_val));

    assert_manual_blocks_frame_R6: assert property (@(posedge clk) disable iff (rst)
        (update_en && wiper_manual && !wiper_wr) |=> $stable(wiper));

    assert_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (update_en && !wiper_manual && !frame_done && !(index_manual && index_wr)) |=> $stable(wiper));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (update_en && !frame_done && !wiper_wr && !index_wr) |=> $stable(wiper));

endmodule

// File: tb/sim_wiper_setting_unit.sv
module sim_wiper_setting_unit;

    localparam int W = 7;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         update_en = 1'b1;
    logic         adder_en = 1'b1;
    logic         wiper_manual = 1'b0;
    logic         index_manual = 1'b0;
    logic [W-1:0] init_val = 7'd0;
    logic [W-1:0] tbl_val = 7'd0;
    logic         frame_done = 1'b0;
    logic         wiper_wr = 1'b0;
    logic [W-1:0] wiper_wdata = 7'd0;
    logic         index_wr = 1'b0;
    logic [W-1:0] wiper;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wiper_setting_unit #(.W(W)) u0 (
        .clk(clk), .rst(rst), .update_en(update_en), .adder_en(adder_en),
        .wiper_manual(wiper_manual), .index_manual(index_manual),
        .init_val(init_val), .tbl_val(tbl_val), .frame_done(frame_done),
        .wiper_wr(wiper_wr), .wiper_wdata(wiper_wdata), .index_wr(index_wr),
        .wiper(wiper)
    );

    function automatic int sat_sum(input int b, input int o);
        int s;
        s = b + ((o >= 64) ? o - 128 : o);
        if (s < 0) s = 0;
        if (s > 127) s = 127;
        return s;
    endfunction

    task automatic check(input string req, input int exp);
        checks++;
        if (int'(wiper) != exp) begin
            errors++;
            $display("FAIL %s: wiper=%0d expected=%0d", req, wiper, exp);
        end
    endtask

    // pulse the given strobes for one clock, then sample one clock later
    task automatic pulse(input bit fd, input bit ww, input bit iw);
        frame_done = fd; wiper_wr = ww; index_wr = iw;
        @(negedge clk);
        frame_done = 0; wiper_wr = 0; index_wr = 0;
    endtask

    task automatic set_known(input int v);
        // direct mode table load brings wiper to a known value
        update_en = 1; adder_en = 0; wiper_manual = 0;
        tbl_val = W'(v);
        pulse(1, 0, 0);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: wiper=%0d expected=finish", wiper);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        init_val = 7'd45;
        @(negedge clk); @(negedge clk);
        check("R1", 45);
        rst = 0;
        @(negedge clk);
        check("R9", 45);  // no frame yet: power-up value holds

        // R2 fixed mode
        update_en = 0;
        for (int v = 0; v < 128; v += 9) begin
            init_val = W'(v);
            tbl_val = W'(127 - v);
            wiper_wdata = W'(v ^ 7'h55);
            wiper_manual = v[0];
            index_manual = 1;
            pulse(1, 1, 1);
            check("R2", v);
        end
        wiper_manual = 0; index_manual = 0;

        // R3 direct sweep
        update_en = 1; adder_en = 0; init_val = 7'd10;
        for (int v = 0; v < 128; v++) begin
            tbl_val = W'(v);
            pulse(1, 0, 0);
            check("R3", v);
        end

        // R4 adder exhaustive
        adder_en = 1;
        for (int b = 0; b < 128; b++) begin
            for (int o = 0; o < 128; o++) begin
                init_val = W'(b); tbl_val = W'(o);
                pulse(1, 0, 0);
                check("R4", sat_sum(b, o));
            end
        end

        // R5 manual write, direct and adder
        init_val = 7'd100; wiper_manual = 1; adder_en = 0;
        wiper_wdata = 7'd33; pulse(0, 1, 0); check("R5", 33);
        adder_en = 1;
        wiper_wdata = 7'd40; pulse(0, 1, 0); check("R5", 127);
        wiper_wdata = 7'h7F; pulse(0, 1, 0); check("R5", 99);
        init_val = 7'd3;
        wiper_wdata = 7'h40; pulse(0, 1, 0); check("R5", 0);

        // R6 manual wiper: frame and index strobes no effect; write wins
        set_known(77);
        wiper_manual = 1; index_manual = 1; tbl_val = 7'd5;
        pulse(1, 0, 0); check("R6", 77);
        pulse(0, 0, 1); check("R6", 77);
        adder_en = 0; wiper_wdata = 7'd12;
        pulse(1, 1, 1); check("R5", 12);
        wiper_manual = 0; index_manual = 0;

        // R7 write ignored when not manual
        set_known(88);
        wiper_wdata = 7'd1;
        pulse(0, 1, 0); check("R7", 88);

        // R8 index apply
        set_known(20);
        index_manual = 0; tbl_val = 7'd60;
        pulse(0, 0, 1); check("R8", 20);
        index_manual = 1;
        pulse(0, 0, 1); check("R8", 60);
        adder_en = 1; init_val = 7'd50; tbl_val = 7'h7B; // -5
        pulse(0, 0, 1); check("R8", 45);
        index_manual = 0;

        // R9 hold with idle strobes while inputs move
        tbl_val = 7'd9; init_val = 7'd1; wiper_wdata = 7'd2;
        @(negedge clk); @(negedge clk);
        check("R9", 45);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule